// File: doc/BRIEF.md
# Pause Frame Receive Detector

This block sits beside the receive side of a full-duplex Ethernet MAC and watches the frame bytes as they arrive, one byte per valid cycle. It takes the MAC control fields from the stream: the length/type word, the opcode and the 16-bit operand. When the frame closes, it decides whether that frame was a flow-control pause request meant for this station. The decision uses two results that other logic supplies: a destination-address hit from the address filter and a frame-good flag from the FCS checker. Preamble removal, CRC computation and address filtering are not part of this block.

A frame opens with a start strobe, which may coincide with its first byte. Its bytes are marked by a data-valid strobe, and it closes with an end-of-frame strobe in a cycle of its own, which carries no byte. The cycle after the end strobe, an accepted frame raises a one-cycle request pulse. The pause time output then carries the operand and holds it until the next accepted frame. A transmit scheduler can load its pause counter from this pulse.

Top module: `pause_frame_detector`

## Requirements
- R1: While reset is active, and after it, before any frame is accepted, `pause_req` is 0 and `pause_time` is 0x0000.
- R2: A frame of exactly 64 counted bytes (FCS included) is accepted when bytes 12..13 hold 0x8808, bytes 14..15 hold 0x0001, and `rx_addr_hit` and `rx_frame_good` are both high in the end-of-frame cycle. `pause_req` is then high for exactly the one cycle after the `rx_eof` cycle.
- R3: When a frame is accepted, `pause_time` takes bytes 16 and 17, with byte 16 as the high byte. It keeps that value until the next accepted frame.
- R4: A frame whose type word is not 0x8808 gives no pulse.
- R5: A frame whose opcode word is not 0x0001 gives no pulse.
- R6: A frame of any length other than 64 gives no pulse. This covers one byte short, one byte long, and lengths beyond the counter range, where the count saturates.
- R7: A frame with `rx_addr_hit` low in its end-of-frame cycle gives no pulse.
- R8: A frame with `rx_frame_good` low in its end-of-frame cycle gives no pulse.
- R9: A rejected frame leaves `pause_time` at its previous value.
- R10: Cycles with `rx_valid` low inside a frame are not counted and capture nothing.
- R11: A start strobe inside an open frame discards the partial frame and begins counting afresh from byte 0.
- R12: An `rx_eof` with no open frame is ignored, even when the address-hit and good flags are high.
- R13: The operand limits 0x0000 and 0xFFFF are reported unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start of frame; may come with byte 0 |
| rx_valid | input | 1 | `rx_data` carries a frame byte this cycle |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End of frame, in a cycle without data |
| rx_addr_hit | input | 1 | Address filter matched the destination; sampled with `rx_eof` |
| rx_frame_good | input | 1 | Frame passed FCS and error checks; sampled with `rx_eof` |
| pause_req | output | 1 | One-cycle pulse for an accepted pause frame |
| pause_time | output | 16 | Operand of the last accepted pause frame |

## Verification
The checks that run on every cycle cover the timing of the pulse and the gating flags. They confirm that a pulse lasts one cycle and always follows an end strobe that came with both the address-hit and good flags. They also confirm that `pause_time` moves only together with a pulse. The content checks can only be shown by the directed scenarios, because each needs a whole frame built byte by byte: the type and opcode comparison, the exact length of 64, big-endian operand capture, gap skipping, restart on a second start strobe, and stray end strobes.

// File: rtl/pause_det_pkg.sv
package pause_det_pkg;

  // Control field values that identify a pause request
  localparam logic [15:0] CTRL_ETHERTYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OPCODE   = 16'h0001;

  // Byte offset of the first control field (type word) inside the frame
  localparam int unsigned CTRL_FIELD_BASE  = 12;
  // Type, opcode and operand: three 16-bit words
  localparam int unsigned CTRL_FIELD_BYTES = 6;

  typedef struct packed {
    logic [15:0] ftype;
    logic [15:0] opcode;
    logic [15:0] operand;
  } ctrl_fields_t;

endpackage

// File: rtl/pause_byte_counter.sv
module pause_byte_counter #(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             valid,
  input  logic             eof,
  output logic             frame_open,
  output logic             byte_take,
  output logic [CNT_W-1:0] byte_idx,
  output logic [CNT_W-1:0] len_now
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic             open_q, open_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cnt_inc;
  logic             cnt_en;

  always_comb begin
    frame_open = open_q | sof;
    byte_idx   = sof ? '0 : cnt_q;
    byte_take  = frame_open & valid;
    cnt_inc    = (byte_idx == CNT_MAX) ? CNT_MAX : byte_idx + 1'b1;
    len_now    = byte_take ? cnt_inc : byte_idx;
    cnt_en     = frame_open;
    cnt_d      = len_now;
    open_d     = frame_open & ~eof;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      open_q <= open_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/pause_field_capture.sv
module pause_field_capture
  import pause_det_pkg::*;
#(
  parameter int unsigned CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             byte_take,
  input  logic [CNT_W-1:0] byte_idx,
  input  logic [7:0]       data,
  output ctrl_fields_t     fields
);

  logic [7:0] fb_q [CTRL_FIELD_BYTES];

  for (genvar k = 0; k < CTRL_FIELD_BYTES; k++) begin : g_slot
    localparam logic [CNT_W-1:0] SLOT_POS = CNT_W'(CTRL_FIELD_BASE + k);
    logic       hit;
    logic       en;
    logic [7:0] nxt;

    always_comb begin
      hit = byte_take && (byte_idx == SLOT_POS);
      en  = hit | sof;
      nxt = hit ? data : 8'h00;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  fb_q[k] <= 8'h00;
      else if (en) fb_q[k] <= nxt;
    end
  end

  // Big-endian: lower offset is the high byte of each word
  always_comb begin
    fields.ftype   = {fb_q[0], fb_q[1]};
    fields.opcode  = {fb_q[2], fb_q[3]};
    fields.operand = {fb_q[4], fb_q[5]};
  end

endmodule

// File: rtl/pause_decision.sv
module pause_decision
  import pause_det_pkg::*;
#(
  parameter int unsigned CNT_W     = 7,
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eof,
  input  logic             frame_open,
  input  logic [CNT_W-1:0] len_now,
  input  ctrl_fields_t     fields,
  input  logic             addr_hit,
  input  logic             frame_good,
  output logic             req,
  output logic [15:0]      ptime
);

  localparam logic [CNT_W-1:0] LEN_EXACT = CNT_W'(FRAME_LEN);

  logic        req_q, req_d;
  logic [15:0] time_q, time_d;
  logic        len_ok, type_ok, op_ok, accept;

  always_comb begin
    len_ok  = (len_now == LEN_EXACT);
    type_ok = (fields.ftype == CTRL_ETHERTYPE);
    op_ok   = (fields.opcode == PAUSE_OPCODE);
    accept  = eof & frame_open & addr_hit & frame_good & len_ok & type_ok & op_ok;
    req_d   = accept;
    time_d  = fields.operand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      time_q <= 16'h0000;
    end else begin
      req_q <= req_d;
      if (accept) time_q <= time_d;
    end
  end

  assign req   = req_q;
  assign ptime = time_q;

endmodule

// File: rtl/pause_frame_detector.sv
module pause_frame_detector
  import pause_det_pkg::*;
#(
  parameter int unsigned FRAME_LEN = 64
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_sof,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_eof,
  input  logic        rx_addr_hit,
  input  logic        rx_frame_good,
  output logic        pause_req,
  output logic [15:0] pause_time
);

  // One extra bit so a saturated count can never alias the exact length
  localparam int unsigned CNT_W = $clog2(FRAME_LEN) + 1;

  logic             frame_open;
  logic             byte_take;
  logic [CNT_W-1:0] byte_idx;
  logic [CNT_W-1:0] len_now;
  ctrl_fields_t     fields;

  pause_byte_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (rx_sof),
    .valid      (rx_valid),
    .eof        (rx_eof),
    .frame_open (frame_open),
    .byte_take  (byte_take),
    .byte_idx   (byte_idx),
    .len_now    (len_now)
  );

  pause_field_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst_n     (rst_n),
    .sof       (rx_sof),
    .byte_take (byte_take),
    .byte_idx  (byte_idx),
    .data      (rx_data),
    .fields    (fields)
  );

  pause_decision #(.CNT_W(CNT_W), .FRAME_LEN(FRAME_LEN)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .eof        (rx_eof),
    .frame_open (frame_open),
    .len_now    (len_now),
    .fields     (fields),
    .addr_hit   (rx_addr_hit),
    .frame_good (rx_frame_good),
    .req        (pause_req),
    .ptime      (pause_time)
  );

endmodule

// File: rtl/pause_frame_detector_chk.sv
module pause_frame_detector_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_eof,
  input logic        rx_addr_hit,
  input logic        rx_frame_good,
  input logic        pause_req,
  input logic [15:0] pause_time
);

  // R2: the request lasts a single cycle
  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pause_req |=> !pause_req);

  // R2: a request always follows an end-of-frame strobe
  p_req_after_eof_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(rx_eof));

  // R7: no request unless the address filter hit at end of frame
  p_req_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(rx_addr_hit));

  // R8: no request unless the frame was good at end of frame
  p_req_needs_good_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pause_req) |-> $past(rx_frame_good));

  // R9: the reported time changes only together with a request
  p_time_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pause_req |-> $stable(pause_time));

endmodule

bind pause_frame_detector pause_frame_detector_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .rx_eof        (rx_eof),
  .rx_addr_hit   (rx_addr_hit),
  .rx_frame_good (rx_frame_good),
  .pause_req     (pause_req),
  .pause_time    (pause_time)
);

// File: tb/pause_frame_detector_tb.sv
module pause_frame_detector_tb;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_sof, rx_valid, rx_eof, rx_addr_hit, rx_frame_good;
  logic [7:0]  rx_data;
  logic        pause_req;
  logic [15:0] pause_time;

  int checks = 0;
  int fails  = 0;
  logic [15:0] last_time;
  logic [7:0]  fb [200];

  always #(CLK_PERIOD/2) clk = ~clk;

  pause_frame_detector u_dut (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_eof(rx_eof), .rx_addr_hit(rx_addr_hit),
    .rx_frame_good(rx_frame_good), .pause_req(pause_req), .pause_time(pause_time)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic build(input int len, input logic [15:0] ty, input logic [15:0] op,
                       input logic [15:0] opnd);
    for (int i = 0; i < 200; i++) fb[i] = 8'(i * 3 + 5);
    fb[0] = 8'h01; fb[1] = 8'h80; fb[2] = 8'hC2;
    fb[12] = ty[15:8];   fb[13] = ty[7:0];
    fb[14] = op[15:8];   fb[15] = op[7:0];
    fb[16] = opnd[15:8]; fb[17] = opnd[7:0];
    if (len < 0) $display("bad length");
  endtask

  task automatic send_bytes(input int len, input bit gaps, input bit do_sof);
    for (int i = 0; i < len; i++) begin
      if (gaps && (i % 7 == 3)) begin
        @(negedge clk);
        rx_sof = 1'b0; rx_valid = 1'b0; rx_data = 8'hEE;
      end
      @(negedge clk);
      rx_sof = (i == 0) && do_sof; rx_valid = 1'b1; rx_data = fb[i];
    end
  endtask

  task automatic end_frame(input bit hit, input bit good);
    @(negedge clk);
    rx_sof = 1'b0; rx_valid = 1'b0; rx_data = 8'h00;
    rx_eof = 1'b1; rx_addr_hit = hit; rx_frame_good = good;
    @(negedge clk);
    rx_eof = 1'b0; rx_addr_hit = 1'b0; rx_frame_good = 1'b0;
  endtask

  // Called at the negedge following the end-of-frame cycle
  task automatic expect_out(input bit exp_req, input logic [15:0] exp_time, input string tag);
    chk(pause_req == exp_req, {tag, " pause_req"}, int'(pause_req), int'(exp_req));
    chk(pause_time == exp_time, {tag, " pause_time"}, int'(pause_time), int'(exp_time));
    @(negedge clk);
    chk(pause_req == 1'b0, {tag, " pulse width"}, int'(pause_req), 0);
    if (exp_req) last_time = exp_time;
  endtask

  task automatic frame(input int len, input logic [15:0] ty, input logic [15:0] op,
                       input logic [15:0] opnd, input bit hit, input bit good,
                       input bit gaps, input bit exp_req, input string tag);
    build(len, ty, op, opnd);
    send_bytes(len, gaps, 1'b1);
    end_frame(hit, good);
    expect_out(exp_req, exp_req ? opnd : last_time, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; rx_sof = 0; rx_valid = 0; rx_data = 0; rx_eof = 0;
    rx_addr_hit = 0; rx_frame_good = 0; last_time = 16'h0000;
    repeat (3) @(negedge clk);
    chk(pause_req == 1'b0, "R1 req in reset", int'(pause_req), 0);
    chk(pause_time == 16'h0, "R1 time in reset", int'(pause_time), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(pause_req == 1'b0, "R1 req after reset", int'(pause_req), 0);
    chk(pause_time == 16'h0, "R1 time after reset", int'(pause_time), 0);
  endtask

  task automatic t_valid;
    frame(64, 16'h8808, 16'h0001, 16'h1234, 1, 1, 0, 1, "R2 R3 valid pause");
    frame(64, 16'h8808, 16'h0001, 16'hA55A, 1, 1, 0, 1, "R3 second operand");
  endtask

  task automatic t_bad_type;
    frame(64, 16'h0800, 16'h0001, 16'h7777, 1, 1, 0, 0, "R4 R9 wrong type");
    frame(64, 16'h8809, 16'h0001, 16'h7777, 1, 1, 0, 0, "R4 type off by one");
  endtask

  task automatic t_bad_op;
    frame(64, 16'h8808, 16'h0002, 16'h6666, 1, 1, 0, 0, "R5 R9 wrong opcode");
    frame(64, 16'h8808, 16'h0101, 16'h6666, 1, 1, 0, 0, "R5 opcode high byte");
  endtask

  task automatic t_length;
    frame(63, 16'h8808, 16'h0001, 16'h5555, 1, 1, 0, 0, "R6 63 bytes");
    frame(65, 16'h8808, 16'h0001, 16'h5555, 1, 1, 0, 0, "R6 65 bytes");
    frame(192, 16'h8808, 16'h0001, 16'h5555, 1, 1, 0, 0, "R6 192 bytes saturated");
  endtask

  task automatic t_flags;
    frame(64, 16'h8808, 16'h0001, 16'h4444, 0, 1, 0, 0, "R7 no address hit");
    frame(64, 16'h8808, 16'h0001, 16'h4444, 1, 0, 0, 0, "R8 frame bad");
  endtask

  task automatic t_gaps;
    frame(64, 16'h8808, 16'h0001, 16'hBEEF, 1, 1, 1, 1, "R10 gaps not counted");
  endtask

  task automatic t_restart;
    build(30, 16'h8808, 16'h0001, 16'h3333);
    send_bytes(30, 0, 1'b1);
    frame(64, 16'h8808, 16'h0001, 16'hC0DE, 1, 1, 0, 1, "R11 restart on sof");
  endtask

  task automatic t_stray_eof;
    end_frame(1, 1);
    expect_out(1'b0, last_time, "R12 stray eof");
  endtask

  task automatic t_limits;
    frame(64, 16'h8808, 16'h0001, 16'h0000, 1, 1, 0, 1, "R13 operand zero");
    frame(64, 16'h8808, 16'h0001, 16'hFFFF, 1, 1, 0, 1, "R13 operand max");
  endtask

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_valid();
    t_bad_type();
    t_bad_op();
    t_length();
    t_flags();
    t_gaps();
    t_restart();
    t_stray_eof();
    t_limits();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule